// File: doc/BRIEF.md
# FSK Carrier to Pulse-Width Converter

This block sits at the front of a frequency-shift-keyed demodulator. It takes the hard-limited received carrier, a single sign bit, and turns every zero crossing into a short, fixed pattern of output levels. After each transition of the sign bit it drives a positive pulse and then a negative pulse. Each pulse lasts one quarter of a period of the centre frequency of the selected receive band. The result is a signed three-level stream. A downstream low-pass averaging filter turns this stream into the baseband data: when crossings come faster than the band centre, the negative half is cut short and the average moves positive.

Two plain select pins choose the receive band. One pin selects the signalling standard and the other gives the local transmit role. The receive band is always the one opposite the local transmit band, and the pulse length comes from a divider of the master clock. The output is a continuous level with a value in every clock cycle, so it has no valid/ready handshake and no back-pressure. The filter downstream must accept one code in every cycle.

Top module: `fsk_pw_conv`

## Requirements
- R1: After reset, and for as long as the sign input does not change, the output code is idle (2'b00).
- R2: Both kinds of sign transition, rising and falling, start a pulse pair. The sign passes through two synchroniser flops and one history flop. The output becomes +1 from the third rising clock edge at which the new level is sampled, counting the first sampling edge as edge 1.
- R3: A pulse pair is exactly N cycles of +1, then exactly N cycles of -1, then idle until the next transition.
- R4: N is the nearest integer to CLK_HZ / (4 * fc), computed as floor((CLK_HZ + 2*fc) / (4*fc)), where fc is the selected centre frequency.
- R5: The receive centre frequency is chosen as follows:
  - standard select 0 (std_v21 = 0): 2125 Hz when tx_answer = 0, 1170 Hz when tx_answer = 1;
  - standard select 1 (std_v21 = 1): 1750 Hz when tx_answer = 0, 1080 Hz when tx_answer = 1.
- R6: A transition that arrives while a pair is in progress, in either half, aborts that pair. A new pair then starts with the same latency as in R2 and lasts the full length.
- R7: The select pins are sampled only when a pair starts. A change in the middle of a pair leaves that pair's length unchanged and takes effect at the next start.
- R8: The output code is two's complement: 2'b01 is +1, 2'b11 is -1 and 2'b00 is idle. The value 2'b10 never appears, so the two pulse levels have equal magnitude and opposite sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sign | input | 1 | Hard-limited received carrier, asynchronous |
| tx_answer | input | 1 | Local transmit role: 1 = answer (receive low band), 0 = originate (receive high band) |
| std_v21 | input | 1 | Standard select: 0 = first channel plan, 1 = second channel plan |
| pw_code | output | 2 | Signed pulse level: 01 = +1, 11 = -1, 00 = idle |

## Verification
Each of the four band configurations is driven with isolated transitions of both polarities. A full cycle-by-cycle trace of each pair shows whether the start latency, the pulse length and the return to idle are right, and whether the pair starts on a rising edge, a falling edge or both. Back-to-back transitions are placed inside the positive half and inside the negative half of a pair. These separate a design that restarts cleanly from one that extends, ignores or merges pairs. The selects are also changed in the middle of a pair to show that the length is latched only when a pair starts. The reset tests cover an idle line and a reset in the middle of a pair.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  typedef enum logic [1:0] {
    PW_IDLE = 2'b00,
    PW_POS  = 2'b01,
    PW_NEG  = 2'b11
  } pw_code_e;

  // quarter-period of fc in master clock cycles, rounded to nearest
  function automatic int unsigned ratio_of(input int unsigned clk_hz,
                                           input int unsigned fc);
    return (clk_hz + 2 * fc) / (4 * fc);
  endfunction

  function automatic int unsigned min4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fpw_edge.sv
module fpw_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sign_in,
  output logic restart
);
  localparam int LAST = SYNC_STAGES;

  // [0..SYNC_STAGES-1] synchroniser, [SYNC_STAGES] history
  logic [LAST:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAST-1:0], sign_in};
  end

  assign restart = sh_q[LAST-1] ^ sh_q[LAST];

endmodule

// File: rtl/fpw_div.sv
module fpw_div #(
  parameter int unsigned CLK_HZ    = 3579545,
  parameter int unsigned FC_A_LO   = 1170,
  parameter int unsigned FC_A_HI   = 2125,
  parameter int unsigned FC_B_LO   = 1080,
  parameter int unsigned FC_B_HI   = 1750,
  parameter int          NUM_CFG   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       busy,
  input  logic [1:0] cfg_sel,
  output logic       tick
);
  localparam int unsigned FC_MIN  = fpw_pkg::min4(FC_A_LO, FC_A_HI, FC_B_LO, FC_B_HI);
  localparam int unsigned MAX_DIV = fpw_pkg::ratio_of(CLK_HZ, FC_MIN);
  localparam int          CNT_W   = $clog2(MAX_DIV + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam int unsigned FC_TAB [NUM_CFG] = '{FC_A_LO, FC_A_HI, FC_B_LO, FC_B_HI};

  logic [CNT_W-1:0] ratio_tab [NUM_CFG];
  logic [CNT_W-1:0] ratio_q;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_ratio
    assign ratio_tab[g] = CNT_W'(fpw_pkg::ratio_of(CLK_HZ, FC_TAB[g]));
  end

  assign tick = busy && (cnt_q == ratio_q - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= ONE;
      cnt_q   <= '0;
    end else if (restart) begin
      ratio_q <= ratio_tab[cfg_sel];
      cnt_q   <= '0;
    end else if (busy) begin
      cnt_q   <= tick ? '0 : cnt_q + ONE;
    end else begin
      cnt_q   <= '0;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(ratio_q));

endmodule

// File: rtl/fpw_seq.sv
module fpw_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  output logic              busy,
  output fpw_pkg::pw_code_e state
);
  import fpw_pkg::*;

  pw_code_e state_d;

  always_comb begin
    state_d = state;
    if (restart) state_d = PW_POS;
    else if (tick) begin
      case (state)
        PW_POS:  state_d = PW_NEG;
        PW_NEG:  state_d = PW_IDLE;
        default: state_d = PW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PW_IDLE;
    else        state <= state_d;
  end

  assign busy = (state != PW_IDLE);

  assert_restart_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> state == PW_POS);

  assert_pos_to_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_POS && tick && !restart) |=> state == PW_NEG);

  assert_neg_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_NEG && tick && !restart) |=> state == PW_IDLE);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_IDLE && !restart) |=> state == PW_IDLE);

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PW_IDLE && !tick && !restart) |=> $stable(state));

endmodule

// File: rtl/fsk_pw_conv.sv
module fsk_pw_conv #(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int unsigned FC_A_LO     = 1170,
  parameter int unsigned FC_A_HI     = 2125,
  parameter int unsigned FC_B_LO     = 1080,
  parameter int unsigned FC_B_HI     = 1750,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_sign,
  input  logic       tx_answer,
  input  logic       std_v21,
  output logic [1:0] pw_code
);
  import fpw_pkg::*;

  logic       restart;
  logic       tick;
  logic       busy;
  logic [1:0] cfg_sel;
  pw_code_e   state;

  // receive band is opposite the transmit band
  assign cfg_sel = {std_v21, ~tx_answer};

  fpw_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sign_in(rx_sign), .restart(restart)
  );

  fpw_div #(
    .CLK_HZ(CLK_HZ), .FC_A_LO(FC_A_LO), .FC_A_HI(FC_A_HI),
    .FC_B_LO(FC_B_LO), .FC_B_HI(FC_B_HI), .NUM_CFG(4)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .busy(busy),
    .cfg_sel(cfg_sel), .tick(tick)
  );

  fpw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .busy(busy), .state(state)
  );

  assign pw_code = state;

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pw_code != 2'b10);

  assert_start_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pw_code == 2'b01);

endmodule

// File: tb/sim_fsk_pw_conv.sv
`timescale 1ns/1ps
module sim_fsk_pw_conv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_sign = 1'b0;
  logic       tx_answer = 1'b0;
  logic       std_v21 = 1'b0;
  logic [1:0] pw_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsk_pw_conv #(.CLK_HZ(100000)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_sign(rx_sign),
    .tx_answer(tx_answer), .std_v21(std_v21), .pw_code(pw_code)
  );

  // {tx_answer, std_v21, N[5:0]}; N from R4 with CLK_HZ = 100000
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 1'b0, 6'd12},  // 2125 Hz
    {1'b1, 1'b0, 6'd21},  // 1170 Hz
    {1'b0, 1'b1, 6'd14},  // 1750 Hz
    {1'b1, 1'b1, 6'd23},  // 1080 Hz
    {1'b1, 1'b0, 6'd21},
    {1'b0, 1'b0, 6'd12},
    {1'b1, 1'b1, 6'd23},
    {1'b0, 1'b1, 6'd14}
  };

  task automatic check_tail(input int n, input int k0, input logic [1:0] prev,
                            input string tag);
    logic [1:0] exp_v;
    bit bad = 1'b0;
    for (int k = k0; k <= 3 + 2 * n + 1; k++) begin
      @(negedge clk);
      if (k < 3)             exp_v = prev;
      else if (k < 3 + n)    exp_v = 2'b01;
      else if (k < 3 + 2*n)  exp_v = 2'b11;
      else                   exp_v = 2'b00;
      if (!bad && pw_code !== exp_v) begin
        bad = 1'b1;
        $display("FAIL %s cycle %0d: pw_code=%b expected %b", tag, k, pw_code, exp_v);
      end
    end
    checks++;
    if (bad) errors++;
  endtask

  task automatic check_pair(input int n, input logic [1:0] prev, input string tag);
    @(negedge clk);
    rx_sign = ~rx_sign;
    check_tail(n, 1, prev, tag);
  endtask

  task automatic toggle_wait(input int m);
    @(negedge clk);
    rx_sign = ~rx_sign;
    repeat (m) @(negedge clk);
  endtask

  task automatic check_idle(input int cycles, input string tag);
    bit bad = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!bad && pw_code !== 2'b00) begin
        bad = 1'b1;
        $display("FAIL %s: pw_code=%b expected 00", tag, pw_code);
      end
    end
    checks++;
    if (bad) errors++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: idle during and after reset
    repeat (3) @(negedge clk);
    checks++;
    if (pw_code !== 2'b00) begin
      errors++;
      $display("FAIL R1 in reset: pw_code=%b expected 00", pw_code);
    end
    rst_n = 1'b1;
    check_idle(20, "R1 after reset");

    // R2 R3 R4 R5 R8: vector table, both edge polarities per band
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tx_answer = VEC[i][7];
      std_v21   = VEC[i][6];
      repeat (3) @(negedge clk);
      check_pair(int'(VEC[i][5:0]), 2'b00,
                 $sformatf("R2 R3 R4 R5 R8 vec %0d sign->%0b", i, ~rx_sign));
    end

    // R6: abort inside the +1 half
    @(negedge clk);
    tx_answer = 1'b0; std_v21 = 1'b0;   // N = 12
    repeat (3) @(negedge clk);
    toggle_wait(5);
    check_pair(12, 2'b01, "R6 abort in +1");

    // R6: abort inside the -1 half
    repeat (3) @(negedge clk);
    toggle_wait(17);
    check_pair(12, 2'b11, "R6 abort in -1");

    // R7: select change mid-pair keeps length, applies at next start
    repeat (3) @(negedge clk);
    toggle_wait(5);
    tx_answer = 1'b1; std_v21 = 1'b1;   // would be N = 23
    check_tail(12, 6, 2'b00, "R7 mid-pair change");
    repeat (3) @(negedge clk);
    check_pair(23, 2'b00, "R7 next start");

    // R1: reset in the middle of a pair
    repeat (3) @(negedge clk);
    toggle_wait(6);
    rst_n = 1'b0;
    #1;
    checks++;
    if (pw_code !== 2'b00) begin
      errors++;
      $display("FAIL R1 mid-pair reset: pw_code=%b expected 00", pw_code);
    end
    rx_sign = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_idle(30, "R1 idle after mid-pair reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule